// File: doc/BRIEF.md
# Transmit Acknowledge Status Registers

This block is a word-addressed status register set for the link layer of a serial bus controller. It keeps the last acknowledge returned for an asynchronous packet. It keeps one record for packets sent from the control transmit queue and a separate record for packets sent from the bulk transmit queue. It also presents a fixed identification word. The link receiver reports each outcome through an update strobe for the queue concerned. With the strobe it gives either a 4-bit bus acknowledge code or one of three link faults: a timeout, an ack that was too long, or an ack that was too short.

Each record folds the outcome into a 5-bit status field and raises a sticky "new" flag. Software polls the record. Reading the record returns the value and clears the flag in the same access. A diagnostic enable bit inside the block opens the status field and the flag to software writes, so that fault handling can be tested without bus traffic.

The bus side takes 32-bit word accesses. Read data is registered and appears one cycle after the request.

Top module: `ack_status_regs`

## Requirements
- R1: A read at offset 0x000 returns 0x1394CE04. The version 0xCE04 is in bits 15:0 and the revision 0x1394 is in bits 31:16. Writes to this offset have no effect.
- R2: On an update with a normal ack (event code 0), the record holds bit 23 = 0 and bits 27:24 = the received 4-bit code, with the code LSB at bit 24.
- R3: On an update with a fault event, bit 23 = 1 and bits 27:24 hold the fault class. Event 1 (timeout) gives 0000, event 2 (ack too long) gives 0001, and event 3 (ack too short) gives 0010.
- R4: Every update sets the new flag at bit 31 of that record.
- R5: A read returns the record's value from before the read, one cycle after the request, and clears the flag at the same time.
- R6: When an update and a read of the same record fall in the same cycle, the read returns the old value. The new value is stored and its flag stays set.
- R7: The control record is at offset 0x004 and the bulk record is at offset 0x008. An update or read of one record leaves the other unchanged.
- R8: While the diagnostic enable is 0, writes to the records change nothing.
- R9: The diagnostic enable is bit 0 at offset 0x030. It can be read and written, and it resets to 0. While it is 1, a write to a record loads bits 27:23 and bit 31 from the write data.
- R10: After reset both records read 0. Bits 22:0 and 30:28 of a record always read 0, and unmapped offsets read 0.
- R11: A hardware update in the same cycle as a diagnostic write to the same record wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up or software) |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request, else 0 |
| ctl_upd | input | 1 | Control-queue ack result strobe |
| ctl_evt | input | 2 | Control event: 0 ack, 1 timeout, 2 too long, 3 too short |
| ctl_code | input | 4 | Control-queue ack code (used when event is 0) |
| blk_upd | input | 1 | Bulk-queue ack result strobe |
| blk_evt | input | 2 | Bulk event, same encoding as ctl_evt |
| blk_code | input | 4 | Bulk-queue ack code (used when event is 0) |

## Verification
The bench targets the collision between a hardware update and a software read. A design that cleared the flag after the update would lose a new result, and one that returned the new value would report an ack that software then never sees flagged. It checks each fault class against its fixed code, which catches swapped error encodings or a misplaced flag bit. It also writes to the records with diagnostics off and on, and with a simultaneous update. A design with the write gate missing, or with the wrong priority, shows altered record contents on the next read.

// File: rtl/ack_pkg.sv
// Package: shared event encoding, offsets and field positions for the
// acknowledge status registers. Assumes byte offsets on a 12-bit bus.
package ack_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ST_W   = 5;   // status field width
    localparam int ST_LO  = 23;  // status field low bit (error flag)
    localparam int NEW_B  = 31;  // new-value flag position

    localparam logic [ADDR_W-1:0] OFF_ID   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CTL  = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_BLK  = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_DIAG = 12'h030;

    localparam logic [15:0] ID_VER = 16'hCE04;
    localparam logic [15:0] ID_REV = 16'h1394;

    typedef enum logic [1:0] {
        EV_ACK     = 2'd0,
        EV_TIMEOUT = 2'd1,
        EV_LONG    = 2'd2,
        EV_SHORT   = 2'd3
    } ack_evt_e;
endpackage

// File: rtl/ack_encode.sv
// ack_encode: folds a receiver result into the 5-bit status field.
// Bit 0 of the status field is the fault flag and bits 4:1 are the code or the
// fault class. Purely combinational.
module ack_encode
    import ack_pkg::*;
(
    input  logic [1:0]      evt,
    input  logic [3:0]      code,
    output logic [ST_W-1:0] status
);
    // Map the event kind onto flag and code bits.
    always_comb begin
        unique case (ack_evt_e'(evt))
            EV_ACK:     status = {code, 1'b0};
            EV_TIMEOUT: status = {4'b0000, 1'b1};
            EV_LONG:    status = {4'b0001, 1'b1};
            EV_SHORT:   status = {4'b0010, 1'b1};
            default:    status = '0;
        endcase
    end
endmodule

// File: rtl/ack_slot.sv
// ack_slot: one acknowledge record, made of the status field and a sticky new flag.
// Priority: hardware update, then diagnostic write, then read-clear.
// Assumes rd and wr are single-cycle decoded strobes for this record.
module ack_slot
    import ack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [ST_W-1:0]   st_in,
    input  logic              rd,
    input  logic              wr,
    input  logic              diag,
    input  logic [ST_W-1:0]   w_field,
    input  logic              w_flag,
    output logic [DATA_W-1:0] word
);
    logic [ST_W-1:0] field_q;
    logic            flag_q;

    // Record state: capture updates, diagnostic loads and read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
            flag_q  <= 1'b0;
        end else if (upd) begin
            field_q <= st_in;
            flag_q  <= 1'b1;
        end else if (wr && diag) begin
            field_q <= w_field;
            flag_q  <= w_flag;
        end else if (rd) begin
            flag_q  <= 1'b0;
        end
    end

    // Place the state into the bus word; every other bit is zero.
    always_comb begin
        word = '0;
        word[ST_LO +: ST_W] = field_q;
        word[NEW_B]         = flag_q;
    end

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> word[NEW_B]);
    // R6
    upd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> word[ST_LO +: ST_W] == $past(st_in));
    // R5
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !upd) |=> !word[NEW_B]);
    // R8
    ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !diag) |=> $stable(word[ST_LO +: ST_W]));
endmodule

// File: rtl/ack_status_regs.sv
// ack_status_regs: top of the acknowledge status register set.
// It decodes 32-bit word accesses and holds the diagnostic enable.
// It instantiates one record per transmit queue and registers the read data
// one cycle after the request. Assumes one access per cycle at most.
module ack_status_regs
    import ack_pkg::*;
#(
    parameter int N_Q = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ctl_upd,
    input  logic [1:0]        ctl_evt,
    input  logic [3:0]        ctl_code,
    input  logic              blk_upd,
    input  logic [1:0]        blk_evt,
    input  logic [3:0]        blk_code
);
    localparam logic [DATA_W-1:0] ID_WORD = {ID_REV, ID_VER};

    logic [ADDR_W-1:0] q_off  [N_Q];
    logic              q_upd  [N_Q];
    logic [1:0]        q_evt  [N_Q];
    logic [3:0]        q_code [N_Q];
    logic [DATA_W-1:0] q_word [N_Q];
    logic              diag_q;
    logic              rd_req, wr_req;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wbits;

    assign rd_req = bus_sel && !bus_wr;
    assign wr_req = bus_sel &&  bus_wr;
    assign unused_wbits = ^{bus_wdata[30:28], bus_wdata[22:1]};

    // Gather the per-queue inputs into arrays indexed by queue.
    always_comb begin
        for (int i = 0; i < N_Q; i++) begin
            q_off[i] = ADDR_W'(OFF_CTL + ADDR_W'(4 * i));
        end
        q_upd[0]  = ctl_upd;  q_evt[0] = ctl_evt;  q_code[0] = ctl_code;
        q_upd[1]  = blk_upd;  q_evt[1] = blk_evt;  q_code[1] = blk_code;
    end

    // One encoder and one record per transmit queue.
    for (genvar g = 0; g < N_Q; g++) begin : g_q
        logic [ST_W-1:0] st;
        ack_encode u_enc (
            .evt    (q_evt[g]),
            .code   (q_code[g]),
            .status (st)
        );
        ack_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd     (q_upd[g]),
            .st_in   (st),
            .rd      (rd_req && bus_addr == q_off[g]),
            .wr      (wr_req && bus_addr == q_off[g]),
            .diag    (diag_q),
            .w_field (bus_wdata[ST_LO +: ST_W]),
            .w_flag  (bus_wdata[NEW_B]),
            .word    (q_word[g])
        );
    end

    // Diagnostic enable register, read-write bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                           diag_q <= 1'b0;
        else if (wr_req && bus_addr == OFF_DIAG) diag_q <= bus_wdata[0];
    end

    // Select the word addressed by the current read.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFF_ID)   rd_mux = ID_WORD;
        if (bus_addr == OFF_DIAG) rd_mux = {{(DATA_W-1){1'b0}}, diag_q};
        for (int i = 0; i < N_Q; i++) begin
            if (bus_addr == q_off[i]) rd_mux = q_word[i];
        end
    end

    // Registered read data, zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    // R1
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_addr == OFF_ID) |=> bus_rdata == 32'h1394CE04);
    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> bus_rdata == '0);
    // R10
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (bus_addr == OFF_CTL || bus_addr == OFF_BLK))
        |=> (bus_rdata[22:0] == '0 && bus_rdata[30:28] == '0));
endmodule

// File: tb/sim_ack_status_regs.sv
// sim_ack_status_regs: directed bench with one task per scenario.
module sim_ack_status_regs;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ctl_upd = 1'b0, blk_upd = 1'b0;
    logic [1:0]  ctl_evt = '0, blk_evt = '0;
    logic [3:0]  ctl_code = '0, blk_code = '0;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ack_status_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctl_upd(ctl_upd), .ctl_evt(ctl_evt), .ctl_code(ctl_code),
        .blk_upd(blk_upd), .blk_evt(blk_evt), .blk_code(blk_code)
    );

    function automatic logic [31:0] rec(bit nf, bit err, logic [3:0] c);
        return {nf, 3'b000, c, err, 23'b0};
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk); d = bus_rdata; bus_sel = 1'b0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] v);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic upd(bit q, logic [1:0] e, logic [3:0] c);
        @(negedge clk);
        if (q) begin blk_upd = 1'b1; blk_evt = e; blk_code = c; end
        else   begin ctl_upd = 1'b1; ctl_evt = e; ctl_code = c; end
        @(negedge clk); ctl_upd = 1'b0; blk_upd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'h004, d); chk("R10 ctl reset", d, 32'h0);
        rd(12'h008, d); chk("R10 blk reset", d, 32'h0);
        rd(12'h030, d); chk("R9 diag reset", d, 32'h0);
        rd(12'h0FC, d); chk("R10 unmapped", d, 32'h0);
    endtask

    task automatic t_id();
        logic [31:0] d;
        rd(12'h000, d); chk("R1 id", d, 32'h1394CE04);
        wr(12'h000, 32'h0);
        rd(12'h000, d); chk("R1 id after write", d, 32'h1394CE04);
    endtask

    task automatic t_normal();
        logic [31:0] d;
        upd(1'b0, 2'd0, 4'hB);
        rd(12'h004, d); chk("R2 R4 R5 ack code", d, rec(1, 0, 4'hB));
        rd(12'h004, d); chk("R5 flag cleared", d, rec(0, 0, 4'hB));
        rd(12'h008, d); chk("R7 bulk untouched", d, 32'h0);
    endtask

    task automatic t_faults();
        logic [31:0] d;
        upd(1'b1, 2'd1, 4'hF);
        rd(12'h008, d); chk("R3 timeout", d, rec(1, 1, 4'b0000));
        upd(1'b1, 2'd2, 4'h0);
        rd(12'h008, d); chk("R3 too long", d, rec(1, 1, 4'b0001));
        upd(1'b1, 2'd3, 4'h0);
        rd(12'h008, d); chk("R3 too short", d, rec(1, 1, 4'b0010));
        rd(12'h004, d); chk("R7 ctl untouched", d, rec(0, 0, 4'hB));
    endtask

    task automatic t_collide();
        logic [31:0] d;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h004;
        ctl_upd = 1'b1; ctl_evt = 2'd0; ctl_code = 4'h2;
        @(negedge clk); d = bus_rdata; bus_sel = 1'b0; ctl_upd = 1'b0;
        chk("R6 old value returned", d, rec(0, 0, 4'hB));
        rd(12'h004, d); chk("R6 new kept flagged", d, rec(1, 0, 4'h2));
    endtask

    task automatic t_diag();
        logic [31:0] d;
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, d); chk("R8 write ignored", d, rec(0, 0, 4'h2));
        wr(12'h030, 32'h1);
        rd(12'h030, d); chk("R9 diag reads 1", d, 32'h1);
        wr(12'h008, rec(1, 1, 4'h9));
        rd(12'h008, d); chk("R9 diag load", d, rec(1, 1, 4'h9));
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h004; bus_wdata = rec(0, 1, 4'h7);
        ctl_upd = 1'b1; ctl_evt = 2'd0; ctl_code = 4'h5;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0; ctl_upd = 1'b0;
        rd(12'h004, d); chk("R11 update wins", d, rec(1, 0, 4'h5));
        wr(12'h030, 32'h0);
        rd(12'h030, d); chk("R9 diag off", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_id();
        t_normal();
        t_faults();
        t_collide();
        t_diag();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule